// File: doc/BRIEF.md
# Dual-Scaling Fixed-Point Multiplier

This block multiplies two numbers held in a dual-scaling fixed-point format. Each operand is N bits wide: one scale-select bit and an (N-1)-bit two's-complement significand. With the scale bit clear, the operand carries P0 fractional bits (fine scale). With it set, it carries P1 fractional bits (coarse scale). P0 must be greater than P1. The result uses the same format, so it can feed further arithmetic of the same kind.

The two significands are multiplied exactly. The product is then brought to a common alignment of 2·P0 fractional bits. A single comparison against the scale boundary picks the output scale. The product is then shifted down to that scale, with truncation toward minus infinity. Products too large for the coarse scale are clamped to its extreme code, and an overflow flag is raised with them. A valid strobe moves alongside the data through three register stages: multiply, align and compare, then shift and clamp.

Top module: `dfx_mul`

## Requirements
- R1: An operand's value is its signed significand times 2^-P0 when its scale bit is 0, and times 2^-P1 when its scale bit is 1. The exact product of the two operand values is the reference for every output field.
- R2: y_exp_o is 0 when the exact product p satisfies -B ≤ p < B, where B = 2^(N-P0-2). Otherwise y_exp_o is 1.
- R3: When y_exp_o is 0, y_sig_o equals floor(p·2^P0) as an (N-1)-bit two's-complement value.
- R4: When y_exp_o is 1 and the value fits, y_sig_o equals floor(p·2^P1).
- R5: When y_exp_o is 1 and floor(p·2^P1) is above 2^(N-2)-1 or below -2^(N-2), y_sig_o is clamped to that bound and ovf_o is 1. In every other case ovf_o is 0.
- R6: A result appears with valid_o high exactly three rising clock edges after the edge that accepted valid_i high. Results leave in the order their operands arrived.
- R7: While rst_ni is low, valid_o, y_exp_o, y_sig_o and ovf_o are all 0.
- R8: A cycle with valid_i low produces no valid_o pulse, whatever the operand inputs hold in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands valid |
| a_exp_i | input | 1 | Scale bit of operand A (1 = coarse) |
| a_sig_i | input | N-1 | Signed significand of operand A |
| b_exp_i | input | 1 | Scale bit of operand B (1 = coarse) |
| b_sig_i | input | N-1 | Signed significand of operand B |
| valid_o | output | 1 | Result valid |
| y_exp_o | output | 1 | Scale bit of the result |
| y_sig_o | output | N-1 | Signed significand of the result |
| ovf_o | output | 1 | Result clamped to the coarse-scale extreme |

## Verification
The hardest outputs to reach are the ones that sit exactly at the scale boundary. These are a product equal to -B, which must stay fine, and a product just below +B. Others are negative products whose floor differs from plain truncation, and coarse products that land exactly on the clamp limits. Each of these comes from one specific pair of significands under one specific mix of scale bits. For that reason the bench builds a small instance (N=8, P0=4, P1=1) and drives every combination of both scale bits and both 7-bit significands. Every boundary and clamp case is therefore certain to occur. Bubble cycles with random operand data are mixed into the stream to exercise the valid path.

// File: rtl/dfx_pkg.sv
package dfx_pkg;
  typedef enum logic {
    SCALE_FINE   = 1'b0,
    SCALE_COARSE = 1'b1
  } scale_e;
endpackage

// File: rtl/dfx_mul_stage.sv
module dfx_mul_stage #(
  parameter int unsigned W  = 31,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          a_exp_i,
  input  logic [W-1:0]  a_sig_i,
  input  logic          b_exp_i,
  input  logic [W-1:0]  b_sig_i,
  output logic          valid_o,
  output logic [1:0]    ncoarse_o,
  output logic [PW-1:0] prod_o
);
  logic signed [W-1:0]  a_s, b_s;
  logic signed [PW-1:0] prod_d;

  assign a_s    = a_sig_i;
  assign b_s    = b_sig_i;
  assign prod_d = PW'(a_s) * PW'(b_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      ncoarse_o <= '0;
      prod_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ncoarse_o <= {1'b0, a_exp_i} + {1'b0, b_exp_i};
        prod_o    <= prod_d;
      end
    end
  end

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  AST_S1_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    valid_o == $past(valid_i)); // R6
  AST_S1_NCOARSE: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    valid_o |-> ncoarse_o <= 2'd2); // R1
endmodule

// File: rtl/dfx_align_stage.sv
module dfx_align_stage #(
  parameter int unsigned N  = 32,
  parameter int unsigned P0 = 16,
  parameter int unsigned P1 = 4,
  localparam int unsigned W  = N - 1,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned D  = P0 - P1,
  localparam int unsigned AW = PW + 2 * D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    ncoarse_i,
  input  logic [PW-1:0] prod_i,
  output logic          valid_o,
  output logic          exp_o,
  output logic [AW-1:0] aligned_o
);
  import dfx_pkg::*;

  localparam logic signed [AW-1:0] BND_POS = AW'(1) << (N + P0 - 2);
  localparam logic signed [AW-1:0] BND_NEG = -BND_POS;

  logic signed [PW-1:0] prod_s;
  logic signed [AW-1:0] ext_s, aligned_d;
  scale_e               exp_d;

  assign prod_s = prod_i;
  assign ext_s  = AW'(prod_s);

  // bring the product to 2*P0 fractional bits
  always_comb begin
    unique case (ncoarse_i)
      2'd0:    aligned_d = ext_s;
      2'd1:    aligned_d = ext_s <<< D;
      default: aligned_d = ext_s <<< (2 * D);
    endcase
    exp_d = (aligned_d >= BND_NEG && aligned_d < BND_POS) ? SCALE_FINE : SCALE_COARSE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      exp_o     <= 1'b0;
      aligned_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        exp_o     <= exp_d;
        aligned_o <= aligned_d;
      end
    end
  end

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  AST_S2_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    valid_o == $past(valid_i)); // R6
  AST_S2_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    $past(valid_i) && $past(prod_i) == '0 |-> !exp_o); // R2
endmodule

// File: rtl/dfx_shift_stage.sv
module dfx_shift_stage #(
  parameter int unsigned N  = 32,
  parameter int unsigned P0 = 16,
  parameter int unsigned P1 = 4,
  localparam int unsigned W  = N - 1,
  localparam int unsigned D  = P0 - P1,
  localparam int unsigned AW = 2 * W + 2 * D
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          exp_i,
  input  logic [AW-1:0] aligned_i,
  output logic          valid_o,
  output logic          exp_o,
  output logic [W-1:0]  sig_o,
  output logic          ovf_o
);
  localparam logic signed [AW-1:0] SMAX   = (AW'(1) << (W - 1)) - AW'(1);
  localparam logic signed [AW-1:0] SMIN   = -(AW'(1) << (W - 1));
  localparam logic [W-1:0]         SAT_HI = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]         SAT_LO = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [AW-1:0] BND    = AW'(1) << (N + P0 - 2);

  logic signed [AW-1:0] al_s, coarse_s;
  logic [W-1:0]         sig_d;
  logic                 ovf_d;

  assign al_s     = aligned_i;
  assign coarse_s = al_s >>> (2 * P0 - P1);

  always_comb begin
    ovf_d = 1'b0;
    if (!exp_i) begin
      sig_d = W'(al_s >>> P0);
    end else if (coarse_s > SMAX) begin
      sig_d = SAT_HI;
      ovf_d = 1'b1;
    end else if (coarse_s < SMIN) begin
      sig_d = SAT_LO;
      ovf_d = 1'b1;
    end else begin
      sig_d = W'(coarse_s);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      exp_o   <= 1'b0;
      sig_o   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        exp_o <= exp_i;
        sig_o <= sig_d;
        ovf_o <= ovf_d;
      end
    end
  end

  logic up_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) up_q <= 1'b0;
    else         up_q <= 1'b1;

  AST_S3_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    valid_o == $past(valid_i)); // R6
  AST_FINE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !exp_i |-> (al_s < BND && al_s >= -BND)); // R2
  AST_OVF_COARSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> exp_o); // R5
  AST_SAT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (sig_o == SAT_HI || sig_o == SAT_LO)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni || !up_q)
    !$past(valid_i) |-> $stable(sig_o) && $stable(exp_o)); // R8
endmodule

// File: rtl/dfx_mul.sv
module dfx_mul #(
  parameter int unsigned N  = 32,
  parameter int unsigned P0 = 16,
  parameter int unsigned P1 = 4,
  localparam int unsigned W  = N - 1,
  localparam int unsigned PW = 2 * W,
  localparam int unsigned AW = PW + 2 * (P0 - P1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         a_exp_i,
  input  logic [W-1:0] a_sig_i,
  input  logic         b_exp_i,
  input  logic [W-1:0] b_sig_i,
  output logic         valid_o,
  output logic         y_exp_o,
  output logic [W-1:0] y_sig_o,
  output logic         ovf_o
);
  logic          s1_valid, s2_valid, s2_exp;
  logic [1:0]    s1_ncoarse;
  logic [PW-1:0] s1_prod;
  logic [AW-1:0] s2_aligned;

  dfx_mul_stage #(.W(W)) i_mul (
    .clk_i, .rst_ni, .valid_i,
    .a_exp_i, .a_sig_i, .b_exp_i, .b_sig_i,
    .valid_o  (s1_valid),
    .ncoarse_o(s1_ncoarse),
    .prod_o   (s1_prod)
  );

  dfx_align_stage #(.N(N), .P0(P0), .P1(P1)) i_align (
    .clk_i, .rst_ni,
    .valid_i  (s1_valid),
    .ncoarse_i(s1_ncoarse),
    .prod_i   (s1_prod),
    .valid_o  (s2_valid),
    .exp_o    (s2_exp),
    .aligned_o(s2_aligned)
  );

  dfx_shift_stage #(.N(N), .P0(P0), .P1(P1)) i_shift (
    .clk_i, .rst_ni,
    .valid_i  (s2_valid),
    .exp_i    (s2_exp),
    .aligned_i(s2_aligned),
    .valid_o  (valid_o),
    .exp_o    (y_exp_o),
    .sig_o    (y_sig_o),
    .ovf_o    (ovf_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o && !ovf_o && y_sig_o == '0); // R7
endmodule

// File: tb/test_dfx_mul.sv
module test_dfx_mul;
  localparam int N = 8, P0 = 4, P1 = 1, W = N - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, a_exp = 1'b0, b_exp = 1'b0;
  logic [W-1:0] a_sig = '0, b_sig = '0;
  logic valid_o, y_exp, ovf;
  logic [W-1:0] y_sig;

  dfx_mul #(.N(N), .P0(P0), .P1(P1)) i_dfx_mul (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .a_exp_i(a_exp), .a_sig_i(a_sig), .b_exp_i(b_exp), .b_sig_i(b_sig),
    .valid_o(valid_o), .y_exp_o(y_exp), .y_sig_o(y_sig), .ovf_o(ovf)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic e; longint s; logic o; longint t; } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, expv, cyc);
    end
  endtask

  // expected result from the exact product, written as integer in units of 2^-(2*P0)
  function automatic exp_t model(input bit ea, input longint sa, input bit eb, input longint sb);
    exp_t r;
    longint fa = ea ? P1 : P0, fb = eb ? P1 : P0;
    longint p = (sa * sb) <<< (2 * P0 - fa - fb);
    longint bnd = longint'(1) <<< (N + P0 - 2);
    longint hi = (longint'(1) <<< (W - 1)) - 1, lo = -(longint'(1) <<< (W - 1));
    r.o = 1'b0;
    if (p >= -bnd && p < bnd) begin
      r.e = 1'b0; r.s = p >>> P0;
    end else begin
      r.e = 1'b1; r.s = p >>> (2 * P0 - P1);
      if (r.s > hi) begin r.s = hi; r.o = 1'b1; end
      if (r.s < lo) begin r.s = lo; r.o = 1'b1; end
    end
    r.t = 0;
    return r;
  endfunction

  task automatic sample();
    exp_t e;
    longint got;
    if (!valid_o) return;
    if (q.size() == 0) begin
      chk(1'b0, "R8 unexpected valid_o", 1, 0);
      return;
    end
    e = q.pop_front();
    got = longint'($signed(y_sig));
    chk(cyc - e.t == 3, "R6 latency", cyc - e.t, 3);
    chk(y_exp == e.e, "R2 y_exp", y_exp, e.e);
    chk(got == e.s, e.e ? "R4 coarse sig" : "R3 fine sig", got, e.s);
    chk(ovf == e.o, "R5 ovf", ovf, e.o);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!valid_o && !ovf && y_sig == '0 && !y_exp, "R7 reset state",
        {valid_o, ovf, y_exp}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      exp_t m;
      if (i % 5 == 0) begin
        @(negedge clk);
        sample();
        valid_i = 1'b0;  // R8 bubble with live-looking data
        a_exp = 1'($urandom); b_exp = 1'($urandom);
        a_sig = W'($urandom); b_sig = W'($urandom);
      end
      @(negedge clk);
      sample();
      valid_i = 1'b1;
      a_exp = i[15]; b_exp = i[14];
      a_sig = i[13:7]; b_sig = i[6:0];
      m = model(a_exp, longint'($signed(a_sig)), b_exp, longint'($signed(b_sig)));
      m.t = cyc;
      q.push_back(m);  // R1
    end
    @(negedge clk);
    sample();
    valid_i = 1'b0;
    repeat (6) begin
      @(negedge clk);
      sample();
    end
    chk(q.size() == 0, "R6 all results delivered", q.size(), 0);
    chk(!valid_o, "R8 idle valid_o", valid_o, 0);
    finish_run();
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL R6 watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule